// File: doc/BRIEF.md
# Buffered Dual-Channel PWM Generator

This block generates pulse-width-modulated waveforms from a single 8-bit up-counter that runs from zero to a programmable period limit and then wraps. Two compare channels share the counter. Each channel drives a primary pin and a secondary pin. The secondary pin rises one counter step after the primary pin falls, so the two pins never overlap. A two-bit mode per channel connects both pins, only one of them, or neither.

New duty values arrive over a simple register port and go into a holding register. They reach the comparator only when the counter sits at its period limit, so each period runs with a single duty value and never produces a truncated or stretched pulse. A read of a duty register returns the value most recently written, even before it takes effect. A duty value of zero, or one equal to the period limit, pins the channel at a steady level.

The counter moves only on cycles where the external step enable is high, so any prescaler can sit outside the block.

Top module: `pwm_dual_buffered`

## Requirements
- R1: The count moves only on clock edges where `tick_en` is high. It steps by one from 0 up to the period limit inclusive, then returns to 0 on the next step.
- R2: A write to a duty register changes only its holding copy. The holding value becomes the active duty on the step taken while the count equals the period limit. A write in that same cycle is committed one period later.
- R3: Reading a duty address returns the holding copy, which is the latest value written.
- R4: Mode 2'b01 drives both pins. The primary pin is cleared when the count reaches the active duty and set when the count reaches 1. The secondary pin is set on the step after the count equalled the active duty and cleared when the count reaches 0. The two pins are never high together.
- R5: Mode 2'b10 drives only the primary pin, with the R4 primary rule. The secondary pin is 0 and its output enable is low.
- R6: Mode 2'b11 drives only the secondary pin, with the R4 secondary rule. The primary pin is 0 and its output enable is low.
- R7: Mode 2'b00 drives both pins of the channel to 0 with both output enables low. An output whose enable is low is always 0.
- R8: An active duty of 0 holds the primary level at 0 and the secondary level at 1. An active duty equal to the period limit (and nonzero) holds the primary level at 1 and the secondary level at 0. Each pin shows its level only where its mode connects it.
- R9: After reset the count, both holding registers and both active duties are 0, the period limit is 8'hFF, and both modes are 2'b00.
- R10: Register addresses are 0 for the channel A duty, 1 for the channel B duty, 2 for the period limit, and 3 for control. In control, bits [1:0] are the channel A mode and bits [3:2] the channel B mode; the other bits read as 0. Period limit and control read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter step enable (prescaled tick) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| count_o | output | 8 | Current counter value |
| pwm_main | output | 2 | Primary pins, bit 0 channel A, bit 1 channel B |
| pwm_alt | output | 2 | Secondary pins, per channel |
| oe_main | output | 2 | Output enable of each primary pin |
| oe_alt | output | 2 | Output enable of each secondary pin |

## Verification
The bench targets four risks:
- A duty write that lands mid-period. A design that commits early would show a pulse of odd length in that period.
- A write in the same cycle as the wrap. A design that forwards the new data into the commit would change duty one period too soon.
- Duty values of 0 and of the period limit. A design without the static override would toggle there, or show a one-count spike.
- A period limit lowered below the running count, a limit of 0, and sparse irregular step enables. A counter that advanced on every clock, or that compared with greater-than, would drift from the reference model within a few cycles.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'b00,
        CH_PAIR = 2'b01,
        CH_MAIN = 2'b10,
        CH_ALT  = 2'b11
    } ch_mode_e;

    typedef struct packed {
        logic main;
        logic alt;
        logic main_oe;
        logic alt_oe;
    } pin_drive_t;

    // Map the two waveform levels onto the pins the mode connects.
    function automatic pin_drive_t route_pins(ch_mode_e m, logic lv_main, logic lv_alt);
        pin_drive_t d;
        d = '0;
        case (m)
            CH_PAIR: begin
                d.main    = lv_main;
                d.alt     = lv_alt;
                d.main_oe = 1'b1;
                d.alt_oe  = 1'b1;
            end
            CH_MAIN: begin
                d.main    = lv_main;
                d.main_oe = 1'b1;
            end
            CH_ALT: begin
                d.alt     = lv_alt;
                d.alt_oe  = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         at_top
);

    logic [W-1:0] cnt_q;

    assign at_top  = (cnt_q == top);
    assign cnt_nxt = at_top ? '0 : cnt_q + W'(1);
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_nxt;
        end
    end

    assert_wrap_at_top_R1: assert property (@(posedge clk) disable iff (rst)
        (tick_en && at_top) |=> (cnt_q == '0));

    assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt_q));

    assert_step_by_one_R1: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !at_top) |=> (cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cnt_nxt,
    input  logic         at_top,
    input  logic [W-1:0] top,
    input  ch_mode_e     mode,
    output logic [W-1:0] hold_o,
    output pin_drive_t   drive_o
);

    logic [W-1:0] hold_q;
    logic [W-1:0] act_q;
    logic [W-1:0] act_nxt;
    logic         commit;
    logic         main_q;
    logic         alt_q;
    logic         sta_lo;
    logic         sta_hi;
    logic         lv_main;
    logic         lv_alt;

    assign commit  = tick_en && at_top;
    assign act_nxt = commit ? hold_q : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            main_q <= 1'b0;
            alt_q  <= 1'b0;
        end else if (tick_en) begin
            act_q <= act_nxt;
            if (cnt_nxt == act_nxt) begin
                main_q <= 1'b0;
            end else if (cnt_nxt == W'(1)) begin
                main_q <= 1'b1;
            end
            if (cnt_nxt == '0) begin
                alt_q <= 1'b0;
            end else if (cnt == act_q) begin
                alt_q <= 1'b1;
            end
        end
    end

    assign sta_lo  = (act_q == '0);
    assign sta_hi  = !sta_lo && (act_q == top);
    assign lv_main = sta_lo ? 1'b0 : (sta_hi ? 1'b1 : main_q);
    assign lv_alt  = sta_lo ? 1'b1 : (sta_hi ? 1'b0 : alt_q);

    assign drive_o = route_pins(mode, lv_main, lv_alt);
    assign hold_o  = hold_q;

    assert_commit_at_top_R2: assert property (@(posedge clk) disable iff (rst)
        commit |=> (act_q == $past(hold_q)));

    assert_active_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(act_q));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        (!sta_lo && !sta_hi) |-> !(main_q && alt_q));

    assert_alt_after_match_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(alt_q) |-> ($past(cnt) == $past(act_q)));

endmodule

// File: rtl/pwm_dual_buffered.sv
module pwm_dual_buffered
    import pwm_pkg::*;
#(
    parameter int W   = 8,
    parameter int NCH = 2,
    localparam int AW = $clog2(NCH + 2),
    localparam int MW = 2 * NCH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_en,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [W-1:0]   reg_wdata,
    output logic [W-1:0]   reg_rdata,
    output logic [W-1:0]   count_o,
    output logic [NCH-1:0] pwm_main,
    output logic [NCH-1:0] pwm_alt,
    output logic [NCH-1:0] oe_main,
    output logic [NCH-1:0] oe_alt
);

    localparam logic [AW-1:0] ADDR_TOP  = AW'(NCH);
    localparam logic [AW-1:0] ADDR_CTRL = AW'(NCH + 1);

    logic [W-1:0]  top_q;
    logic [MW-1:0] mode_q;
    logic [W-1:0]  cnt;
    logic [W-1:0]  cnt_nxt;
    logic          at_top;
    logic [W-1:0]  hold_v [NCH];
    pin_drive_t    drv    [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q  <= '1;
            mode_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_TOP)  top_q  <= reg_wdata;
            if (reg_addr == ADDR_CTRL) mode_q <= reg_wdata[MW-1:0];
        end
    end

    pwm_tick_counter #(.W(W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .top     (top_q),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .at_top  (at_top)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick_en (tick_en),
            .wr_en   (reg_wr && (reg_addr == AW'(g))),
            .wr_data (reg_wdata),
            .cnt     (cnt),
            .cnt_nxt (cnt_nxt),
            .at_top  (at_top),
            .top     (top_q),
            .mode    (ch_mode_e'(mode_q[2*g +: 2])),
            .hold_o  (hold_v[g]),
            .drive_o (drv[g])
        );

        assign pwm_main[g] = drv[g].main;
        assign pwm_alt[g]  = drv[g].alt;
        assign oe_main[g]  = drv[g].main_oe;
        assign oe_alt[g]   = drv[g].alt_oe;

        assert_off_main_low_R7: assert property (@(posedge clk) disable iff (rst)
            !oe_main[g] |-> !pwm_main[g]);

        assert_off_alt_low_R7: assert property (@(posedge clk) disable iff (rst)
            !oe_alt[g] |-> !pwm_alt[g]);
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == AW'(i)) reg_rdata = hold_v[i];
        end
        if (reg_addr == ADDR_TOP)  reg_rdata = top_q;
        if (reg_addr == ADDR_CTRL) reg_rdata = W'(mode_q);
    end

    assign count_o = cnt;

endmodule

// File: tb/test_pwm_dual_buffered.sv
`timescale 1ns/1ps
module test_pwm_dual_buffered;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [7:0] count_o;
    logic [1:0] pwm_main, pwm_alt, oe_main, oe_alt;

    always #2.5 clk = ~clk;

    pwm_dual_buffered i_pwm_dual_buffered (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .count_o(count_o), .pwm_main(pwm_main), .pwm_alt(pwm_alt),
        .oe_main(oe_main), .oe_alt(oe_alt)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural reference state
    int m_cnt, m_top;
    int m_hold[2], m_act[2], m_mode[2], m_nq[2], m_cq[2];

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_top = 255;
            for (int c = 0; c < 2; c++) begin
                m_hold[c] = 0; m_act[c] = 0; m_mode[c] = 0; m_nq[c] = 0; m_cq[c] = 0;
            end
        end else begin
            if (tick_en) begin
                int nc;
                nc = (m_cnt == m_top) ? 0 : (m_cnt + 1) % 256;
                for (int c = 0; c < 2; c++) begin
                    int na;
                    na = (m_cnt == m_top) ? m_hold[c] : m_act[c];
                    if (nc == na) m_nq[c] = 0;
                    else if (nc == 1) m_nq[c] = 1;
                    if (nc == 0) m_cq[c] = 0;
                    else if (m_cnt == m_act[c]) m_cq[c] = 1;
                    m_act[c] = na;
                end
                m_cnt = nc;
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_hold[0] = reg_wdata;
                    2'd1: m_hold[1] = reg_wdata;
                    2'd2: m_top = reg_wdata;
                    default: begin
                        m_mode[0] = reg_wdata[1:0];
                        m_mode[1] = reg_wdata[3:2];
                    end
                endcase
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_rd;
        chk("R1 count", count_o, m_cnt);
        case (reg_addr)
            2'd0: exp_rd = m_hold[0];
            2'd1: exp_rd = m_hold[1];
            2'd2: exp_rd = m_top;
            default: exp_rd = m_mode[0] | (m_mode[1] << 2);
        endcase
        chk((reg_addr < 2) ? "R3 duty readback" : "R10 register readback", reg_rdata, exp_rd);
        for (int c = 0; c < 2; c++) begin
            int lo, hi, lm, la, em, ea, eom, eoa;
            string tag;
            lo = (m_act[c] == 0);
            hi = !lo && (m_act[c] == m_top);
            lm = lo ? 0 : (hi ? 1 : m_nq[c]);
            la = lo ? 1 : (hi ? 0 : m_cq[c]);
            em = 0; ea = 0; eom = 0; eoa = 0;
            case (m_mode[c])
                1: begin em = lm; ea = la; eom = 1; eoa = 1; tag = "R4 pair"; end
                2: begin em = lm; eom = 1; tag = "R5 main only"; end
                3: begin ea = la; eoa = 1; tag = "R6 alt only"; end
                default: tag = "R7 off";
            endcase
            if (m_mode[c] != 0 && (lo || hi)) tag = "R8 static level";
            chk({tag, " main"}, pwm_main[c], em);
            chk({tag, " alt"}, pwm_alt[c], ea);
            chk({tag, " oe_main"}, oe_main[c], eom);
            chk({tag, " oe_alt"}, oe_alt[c], eoa);
            if (m_mode[c] == 1 && !lo && !hi)
                chk("R4 no overlap", pwm_main[c] & pwm_alt[c], 0);
        end
    endtask

    int tick_sel = 0;
    int tick_phase = 0;
    logic [7:0] lfsr = 8'hA5;
    logic [1:0] rd_ptr = 2'd0;

    function automatic logic next_tick();
        tick_phase++;
        case (tick_sel)
            0: return 1'b1;
            1: return (tick_phase % 3) == 0;
            default: begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                return lfsr[0] | lfsr[2];
            end
        endcase
    endfunction

    task automatic step(bit wr, logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        if (!rst) compare_all();
        tick_en = rst ? 1'b0 : next_tick();
        reg_wr = wr;
        if (wr) begin
            reg_addr = a;
            reg_wdata = d;
        end else begin
            reg_addr = rd_ptr;
            rd_ptr = rd_ptr + 2'd1;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, 8'd0);
    endtask

    task automatic wreg(logic [1:0] a, logic [7:0] d);
        step(1, a, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        idle(3);
        @(negedge clk);
        rst = 1'b0;
        tick_en = 1'b0;
        reg_wr = 1'b0;
        reg_addr = 2'd2;
        @(negedge clk);
        // R9: reset state seen at the ports
        chk("R9 count after reset", count_o, 0);
        chk("R9 period limit after reset", reg_rdata, 255);
        chk("R9 outputs off after reset", {pwm_main, pwm_alt, oe_main, oe_alt}, 0);
        reg_addr = 2'd0;
        @(negedge clk);
        chk("R9 duty A hold after reset", reg_rdata, 0);
        reg_addr = 2'd3;
        @(negedge clk);
        chk("R9 modes after reset", reg_rdata, 0);

        // R10 map, R4/R5 waveforms with a short period
        tick_sel = 0;
        wreg(2'd2, 8'd9);
        wreg(2'd3, 8'b1001);
        wreg(2'd0, 8'd4);
        wreg(2'd1, 8'd7);
        idle(45);
        // R2: duty change mid-period is deferred to the wrap
        wreg(2'd0, 8'd6);
        idle(40);

        // R6 and R7 with sparse regular ticks
        tick_sel = 1;
        wreg(2'd3, 8'b0011);
        idle(70);

        // R8 static levels at 0 and at the period limit
        wreg(2'd0, 8'd0);
        wreg(2'd1, 8'd9);
        wreg(2'd3, 8'b0101);
        idle(70);
        wreg(2'd0, 8'd9);
        wreg(2'd1, 8'd0);
        wreg(2'd3, 8'b1101);
        idle(70);

        // Full-length period with irregular ticks
        tick_sel = 2;
        wreg(2'd2, 8'd255);
        wreg(2'd3, 8'b0110);
        wreg(2'd0, 8'd100);
        wreg(2'd1, 8'd200);
        idle(900);

        // R1: limit lowered below the running count, then limit 0
        tick_sel = 0;
        wreg(2'd2, 8'd3);
        idle(300);
        wreg(2'd2, 8'd0);
        idle(20);

        // R2: back-to-back writes around the wrap
        wreg(2'd2, 8'd5);
        wreg(2'd3, 8'b0101);
        for (int k = 0; k < 40; k++) wreg(2'(k % 2), 8'(k % 6));
        idle(30);

        finish_run();
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule